// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every data beat of one burst inside a 256-column SDRAM page. A burst begins when `start_i` is sampled high. The block captures the start column, the length code and the ordering bit at that edge. On the following clock it presents beat 0, then one beat per clock after that. Each beat comes with a valid flag, and a last flag marks the final beat of a fixed-length burst.

A controller that follows data beats uses it to learn which column each beat touches. A memory model uses it to pick the cell for each beat. Two orderings are supported. Sequential ordering counts up and wraps inside the aligned block. Interleaved ordering XORs the beat number into the low bits. A full-page burst counts through the whole page and wraps. It continues until it is terminated or restarted.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and at the first sample after it, `beat_valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a clock edge, from that edge `beat_valid_o` is 1 and `col_o` equals the captured `start_col_i` (beat 0).
- R3: Length codes on `len_code_i`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page (256 beats, wrapping). Codes 4, 5 and 6 give 1 beat.
- R4: Sequential ordering (`interleave_i` = 0), length BL = 2^n: beat k has column (S with its low n bits cleared) OR ((S + k) mod BL), where S is the start column. The upper bits stay fixed.
- R5: Interleaved ordering (`interleave_i` = 1, fixed length): beat k has column S XOR k.
- R6: Full page ignores `interleave_i`. Beat k has column (S + k) mod 256, so column 255 is followed by 0. It never raises `last_o` and runs until it is stopped or restarted.
- R7: `last_o` is 1 exactly on the final beat (k = BL-1) of a fixed-length burst. After that beat, `beat_valid_o` falls unless a new start arrives at the same edge.
- R8: `stop_i` high at an edge during a burst, with `start_i` low, makes `beat_valid_o` 0 from that edge. `stop_i` has no effect while idle. When it arrives together with `start_i`, the start wins.
- R9: A start during an active burst abandons the old burst. Beat 0 of the new burst is presented from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new burst with the values below |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| stop_i | input | 1 | Terminate the active burst |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| col_o | output | COL_W | Column of the current beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter or captured start column appears on `col_o` in the very cycle it goes wrong, since the column is formed combinationally from that state. A wrong stored length shows up differently. It either moves the fall of `beat_valid_o` or misplaces `last_o`, and this becomes visible at the end of the burst, no later than 8 beats after the start. For full-page bursts, a carry fault at the page boundary is visible only at the beat that crosses 255. For that reason the stimulus deliberately runs bursts across that wrap.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8,
  parameter logic [2:0] FULL_CODE = 3'd7,
  parameter int FIXED_CODES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);

  logic             active_q, full_q, inter_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_in, sum;
  logic             full_in;

  assign full_in = (len_code_i == FULL_CODE);

  always_comb begin
    if (full_in)
      mask_in = '1;
    else if (int'(len_code_i) < FIXED_CODES)
      mask_in = COL_W'((1 << len_code_i) - 1);
    else
      mask_in = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      inter_q  <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_in;
      inter_q  <= interleave_i && !full_in;
      base_q   <= start_col_i;
      beat_q   <= '0;
      mask_q   <= mask_in;
    end else if (active_q) begin
      if (stop_i || last_o)
        active_q <= 1'b0;
      else
        beat_q <= beat_q + 1'b1;
    end
  end

  assign sum          = base_q + beat_q;
  assign beat_valid_o = active_q;
  assign col_o        = !active_q ? '0 :
                        inter_q   ? (base_q ^ beat_q) :
                                    ((base_q & ~mask_q) | (sum & mask_q));
  assign last_o       = active_q && !full_q && (beat_q == mask_q);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_valid_o && (col_o == $past(start_col_i)));            // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && stop_i && !start_i |=> !beat_valid_o);                 // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid_o && !start_i |=> !beat_valid_o);                          // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !beat_valid_o);                                 // R7
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);                                              // R7
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && full_q |-> !last_o);                                   // R6
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !inter_q && !start_i && !stop_i && !last_o |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))));             // R4

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             beat_valid_o, last_o;
  logic [COL_W-1:0] col_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bit       m_act = 1'b0;
  int       m_s = 0, m_k = 0, m_code = 0;
  bit       m_int = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .beat_valid_o(beat_valid_o), .col_o(col_o), .last_o(last_o));

  // R3: length per code
  function automatic int f_len(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int f_col(int s, int k, int code, bit inter);
    int len = f_len(code);
    int msk = len - 1;
    if (len == 256) return (s + k) % 256;                   // R6
    if (inter) return (s ^ k) & 255;                         // R5
    return (s & ~msk & 255) | ((s + k) & msk);               // R4
  endfunction

  function automatic bit f_last();
    return m_act && f_len(m_code) != 256 && m_k == f_len(m_code) - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    string ctag;
    check("R2 R7 R8 R9 valid", beat_valid_o, m_act);
    check("R7 last", last_o, f_last());
    if (m_act) begin
      ctag = (f_len(m_code) == 256) ? "R6 col" : (m_int ? "R5 col" : "R4 col");
      check(ctag, col_o, f_col(m_s, m_k, m_code, m_int));
    end
  endtask

  task automatic step(bit st, int col, int code, bit inter, bit sp);
    bit lst = f_last();
    start_i = st; start_col_i = COL_W'(col); len_code_i = 3'(code);
    interleave_i = inter; stop_i = sp;
    if (st) begin
      m_act = 1'b1; m_s = col; m_k = 0; m_code = code; m_int = inter;
    end else if (m_act) begin
      if (sp || lst) m_act = 1'b0;
      else m_k = (m_k + 1) % 256;
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", beat_valid_o, 0);
    check("R1 last", last_o, 0);
    check("R1 col", col_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", beat_valid_o, 0);

    // R4 sequential length 4 wrapping inside the aligned block
    step(1, 8'h2E, 2, 0, 0);
    repeat (4) step(0, 0, 0, 0, 0);
    // R5 interleaved length 8
    step(1, 8'h35, 3, 1, 0);
    repeat (8) step(0, 0, 0, 0, 0);
    // R6 full page ignores interleave and wraps past 255
    step(1, 8'hFA, 7, 1, 0);
    repeat (270) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);            // R8 stop ends full page
    step(0, 0, 0, 0, 0);
    // R8 stop while idle is ignored
    step(0, 0, 0, 0, 1);
    // R9 restart mid-burst
    step(1, 8'h10, 3, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 8'hC3, 1, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0);
    // R3 reserved code 5 acts as length 1
    step(1, 8'h77, 5, 0, 0);
    step(0, 0, 0, 0, 0);
    // R8 start beats stop at the same edge
    step(1, 8'h40, 3, 0, 0);
    step(1, 8'h81, 2, 1, 1);
    repeat (4) step(0, 0, 0, 0, 0);
    // R7 back-to-back length-1 bursts
    step(1, 8'h01, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int c = $urandom_range(0, 9);
      int code = (c > 7) ? 7 : c;
      bit st = ($urandom_range(0, 5) == 0);
      bit sp = ($urandom_range(0, 19) == 0);
      step(st, $urandom_range(0, 255), code, 1'($urandom_range(0, 1)), sp);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule